// File: doc/BRIEF.md
# Frame-Based ARINC 429 Transmit Buffer

This block sits between a host processor bus and the 16-bit parallel load port of an external ARINC 429 transceiver. The host fills a small word store with up to twenty 32-bit words and then writes a go command. From then on the block works in the background. It waits for the transceiver to signal that it can accept a word. It then presents that word as two 16-bit halves, each with its own write strobe, and moves on to the next word. When the last word has been handed over, it raises an interrupt.

The host needs no per-word involvement. It can watch a busy flag, the current word count and a copy of the transceiver's ready line. A control write can abort and empty the buffer at any time. The serial line encoding is the transceiver's job. Address decoding is done outside the block: a single select input tells data writes apart from control writes.

Top module: `a429_tx_frame_buf`

## Requirements
- R1: After reset, busy, irq, xcvr_wr and word_count are all 0.
- R2: A data write (host_we=1, host_ctrl=0) while idle stores host_wdata in the next free slot and increments word_count. Once word_count reaches 20, further data writes are ignored and the stored words are unchanged.
- R3: A control write (host_we=1, host_ctrl=1) with bit 0 (go) set, made while idle with word_count>0, sets busy. A go with word_count=0 is ignored: busy and irq stay 0.
- R4: Each word leaves as two one-cycle xcvr_wr pulses on xcvr_data: bits 15:0 first, then bits 31:16. There is at least one cycle with xcvr_wr low between any two pulses.
- R5: The low-half pulse of a word is issued only after xcvr_ready was seen high in the previous cycle. After a high-half pulse, xcvr_ready is not sampled again for one settle cycle.
- R6: Exactly word_count words are sent, in the order in which they were written.
- R7: On completion, busy falls, word_count returns to 0 and irq rises. When xcvr_ready stays high, busy lasts exactly 5n−1 cycles for an n-word frame.
- R8: irq stays high until a control write with bit 2 (acknowledge) set.
- R9: While busy, data writes and go commands are ignored. word_count is unchanged, and no extra words are sent.
- R10: A control write with bit 1 (flush) clears word_count and busy at once and stops further strobes, without raising irq. Flush wins over go in the same write.
- R11: host_xcvr_ready always equals xcvr_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe, one cycle |
| host_ctrl | input | 1 | 1 = control write, 0 = data write |
| host_wdata | input | 32 | Host write data (control: bit0 go, bit1 flush, bit2 acknowledge) |
| busy | output | 1 | Frame transmission in progress |
| word_count | output | 5 | Words currently loaded |
| irq | output | 1 | Frame-complete interrupt, held until acknowledged |
| host_xcvr_ready | output | 1 | Copy of transceiver ready for polling |
| xcvr_ready | input | 1 | Transceiver can accept a word |
| xcvr_data | output | 16 | Half-word to the transceiver |
| xcvr_wr | output | 1 | Load strobe for xcvr_data |

## Verification
The assertions assume that host writes are single-cycle pulses and that xcvr_ready is synchronous to clk. They also assume that a transceiver drops ready within one cycle of the high-half strobe if it needs time to serialise. The bench drives every host write as a one-cycle pulse at the falling edge. Its transceiver model lowers ready at the high-half strobe for a programmable number of cycles, or keeps it high throughout, so every pacing case stays within those assumptions.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_LO,
        ST_GAP,
        ST_HI,
        ST_SETTLE
    } seq_state_t;

    localparam int CTRL_GO_BIT    = 0;
    localparam int CTRL_FLUSH_BIT = 1;
    localparam int CTRL_ACK_BIT   = 2;
endpackage

// File: rtl/a429_tx_store.sv
module a429_tx_store #(
    parameter int DEPTH  = 20,
    parameter int WORD_W = 32,
    localparam int AW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < DEPTH)) begin
            mem_q[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (int'(raddr) < DEPTH) begin
            rdata = mem_q[raddr];
        end
    end
endmodule

// File: rtl/a429_tx_fill.sv
module a429_tx_fill #(
    parameter int DEPTH = 20,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          data_we,
    input  logic          busy,
    input  logic          flush,
    input  logic          done,
    output logic          ram_we,
    output logic [CW-1:0] ram_waddr,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [CW-1:0] count;
    } fill_t;

    fill_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        ram_we = data_we && !busy && !flush && (int'(st_q.count) < DEPTH);
        if (flush || done) begin
            st_d.count = '0;
        end else if (ram_we) begin
            st_d.count = st_q.count + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ram_waddr = st_q.count;
    assign count     = st_q.count;

    assert_count_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH);

    assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !flush && !done) |=> $stable(count));

    assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));
endmodule

// File: rtl/a429_tx_seq.sv
module a429_tx_seq
    import a429_tx_pkg::*;
#(
    parameter int DEPTH  = 20,
    parameter int WORD_W = 32,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int HALF  = WORD_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              flush,
    input  logic              ack,
    input  logic [CW-1:0]     count,
    input  logic [WORD_W-1:0] rdata,
    input  logic              xcvr_ready,
    output logic [CW-1:0]     raddr,
    output logic              busy,
    output logic              done,
    output logic              irq,
    output logic [HALF-1:0]   xcvr_data,
    output logic              xcvr_wr
);
    typedef struct packed {
        seq_state_t      state;
        logic [CW-1:0]   idx;
        logic [CW-1:0]   last;
        logic [HALF-1:0] data;
        logic            wr;
        logic            irq;
    } seq_t;

    seq_t st_d, st_q;
    logic is_busy;
    logic start;

    assign is_busy = (st_q.state != ST_IDLE);
    assign start   = go && !flush && !is_busy && (count != '0);

    always_comb begin
        st_d    = st_q;
        st_d.wr = 1'b0;
        done    = 1'b0;
        if (ack) begin
            st_d.irq = 1'b0;
        end
        unique case (st_q.state)
            ST_IDLE: begin
                if (start) begin
                    st_d.state = ST_WAIT;
                    st_d.idx   = '0;
                    st_d.last  = count - CW'(1);
                end
            end
            ST_WAIT: begin
                if (xcvr_ready) begin
                    st_d.state = ST_LO;
                    st_d.data  = rdata[HALF-1:0];
                    st_d.wr    = 1'b1;
                end
            end
            ST_LO: begin
                st_d.state = ST_GAP;
            end
            ST_GAP: begin
                st_d.state = ST_HI;
                st_d.data  = rdata[WORD_W-1:HALF];
                st_d.wr    = 1'b1;
            end
            ST_HI: begin
                if (st_q.idx == st_q.last) begin
                    st_d.state = ST_IDLE;
                    st_d.irq   = 1'b1;
                    done       = 1'b1;
                end else begin
                    st_d.state = ST_SETTLE;
                    st_d.idx   = st_q.idx + CW'(1);
                end
            end
            ST_SETTLE: begin
                st_d.state = ST_WAIT;
            end
            default: begin
                st_d.state = ST_IDLE;
            end
        endcase
        if (flush) begin
            st_d.state = ST_IDLE;
            st_d.wr    = 1'b0;
            st_d.irq   = st_q.irq && !ack;
            done       = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign raddr     = st_q.idx;
    assign busy      = is_busy;
    assign irq       = st_q.irq;
    assign xcvr_data = st_q.data;
    assign xcvr_wr   = st_q.wr;

    assert_strobe_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xcvr_wr |=> !xcvr_wr);

    assert_low_after_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_LO) |-> $past(xcvr_ready));

    assert_strobe_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xcvr_wr |-> busy);

    assert_irq_on_finish_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $fell(busy));

    assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !$past(ack)) |-> $past(irq) || $fell(busy));
endmodule

// File: rtl/a429_tx_frame_buf.sv
module a429_tx_frame_buf
    import a429_tx_pkg::*;
#(
    parameter int DEPTH  = 20,
    parameter int WORD_W = 32,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int HALF  = WORD_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic              host_ctrl,
    input  logic [WORD_W-1:0] host_wdata,
    output logic              busy,
    output logic [CW-1:0]     word_count,
    output logic              irq,
    output logic              host_xcvr_ready,
    input  logic              xcvr_ready,
    output logic [HALF-1:0]   xcvr_data,
    output logic              xcvr_wr
);
    logic              data_we;
    logic              ctrl_we;
    logic              go;
    logic              flush;
    logic              ack;
    logic              done;
    logic              ram_we;
    logic [CW-1:0]     ram_waddr;
    logic [CW-1:0]     ram_raddr;
    logic [WORD_W-1:0] ram_rdata;

    assign data_we = host_we && !host_ctrl;
    assign ctrl_we = host_we && host_ctrl;
    assign go      = ctrl_we && host_wdata[CTRL_GO_BIT];
    assign flush   = ctrl_we && host_wdata[CTRL_FLUSH_BIT];
    assign ack     = ctrl_we && host_wdata[CTRL_ACK_BIT];

    assign host_xcvr_ready = xcvr_ready;

    a429_tx_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (host_wdata),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    a429_tx_fill #(.DEPTH(DEPTH)) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_we   (data_we),
        .busy      (busy),
        .flush     (flush),
        .done      (done),
        .ram_we    (ram_we),
        .ram_waddr (ram_waddr),
        .count     (word_count)
    );

    a429_tx_seq #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .flush      (flush),
        .ack        (ack),
        .count      (word_count),
        .rdata      (ram_rdata),
        .xcvr_ready (xcvr_ready),
        .raddr      (ram_raddr),
        .busy       (busy),
        .done       (done),
        .irq        (irq),
        .xcvr_data  (xcvr_data),
        .xcvr_wr    (xcvr_wr)
    );
endmodule

// File: tb/a429_tx_frame_buf_test.sv
module a429_tx_frame_buf_test;
    localparam int DEPTH = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic        host_ctrl = 1'b0;
    logic [31:0] host_wdata = '0;
    logic        busy;
    logic [4:0]  word_count;
    logic        irq;
    logic        host_xcvr_ready;
    logic        xcvr_ready = 1'b1;
    logic [15:0] xcvr_data;
    logic        xcvr_wr;

    int errors = 0;
    int checks = 0;
    int lat = 0;
    int wait_left = 0;
    logic half_sel = 1'b0;
    logic prev_wr = 1'b0;
    logic prev_ready = 1'b1;
    logic [15:0] lo_half = '0;
    logic [31:0] rx [0:31];
    int rx_n = 0;
    logic [31:0] sent [0:31];
    logic finished = 1'b0;

    always #5 clk = ~clk;

    a429_tx_frame_buf uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .host_we         (host_we),
        .host_ctrl       (host_ctrl),
        .host_wdata      (host_wdata),
        .busy            (busy),
        .word_count      (word_count),
        .irq             (irq),
        .host_xcvr_ready (host_xcvr_ready),
        .xcvr_ready      (xcvr_ready),
        .xcvr_data       (xcvr_data),
        .xcvr_wr         (xcvr_wr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // transceiver model and strobe monitor, all at the falling edge
    always @(negedge clk) begin
        if (xcvr_wr) begin
            if (prev_wr) check(0, "R4", "back-to-back strobes", 1, 0);
            if (!half_sel) begin
                if (!prev_ready) check(0, "R5", "low half without ready", 0, 1);
                lo_half = xcvr_data;
                half_sel = 1'b1;
            end else begin
                if (rx_n < 32) rx[rx_n] = {xcvr_data, lo_half};
                rx_n++;
                half_sel = 1'b0;
                if (lat > 0) begin
                    xcvr_ready = 1'b0;
                    wait_left = lat;
                end
            end
        end else if (wait_left > 0) begin
            wait_left--;
            if (wait_left == 0) xcvr_ready = 1'b1;
        end
        prev_wr = xcvr_wr;
        prev_ready = xcvr_ready;
    end

    task automatic host_write(input logic ctrl, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1;
        host_ctrl = ctrl;
        host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
        host_ctrl = 1'b0;
        host_wdata = '0;
    endtask

    task automatic clear_rx();
        rx_n = 0;
        half_sel = 1'b0;
    endtask

    task automatic wait_idle(output int cycles);
        cycles = 0;
        while (busy && cycles < 5000) begin
            @(negedge clk);
            cycles++;
        end
        if (busy) check(0, "R7", "timeout waiting for idle", 1, 0);
    endtask

    function automatic logic [31:0] pat(input int n, input int i);
        return 32'h5A00_0000 ^ (32'(n) << 16) ^ (32'(i) * 32'h0101_0101) ^ 32'(i * 7 + n);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy == 0 && irq == 0 && xcvr_wr == 0 && word_count == 0, "R1",
              "reset state", {busy, irq, xcvr_wr, word_count}, 0);
        check(host_xcvr_ready == xcvr_ready, "R11", "ready mirror high",
              host_xcvr_ready, xcvr_ready);

        // R3 go with empty buffer
        host_write(1'b1, 32'h1);
        repeat (3) @(negedge clk);
        check(busy == 0 && irq == 0, "R3", "go with empty buffer", {busy, irq}, 0);

        // sweep of frame lengths and ready latencies
        for (int n = 1; n <= DEPTH; n++) begin
            lat = n % 4;
            clear_rx();
            for (int i = 0; i < n; i++) begin
                sent[i] = pat(n, i);
                host_write(1'b0, sent[i]);
            end
            check(word_count == 5'(n), "R2", "count after loading", word_count, n);
            host_write(1'b1, 32'h1);
            check(busy == 1, "R3", "busy after go", busy, 1);
            wait_idle(cyc);
            if (lat == 0)
                check(cyc == 5 * n - 1, "R7", "busy duration", cyc, 5 * n - 1);
            @(negedge clk);
            check(rx_n == n, "R6", "words sent", rx_n, n);
            for (int i = 0; i < n && i < 32; i++)
                check(rx[i] == sent[i], "R6", "word value/order", rx[i], sent[i]);
            check(word_count == 0 && irq == 1, "R7", "completion state",
                  {irq, word_count}, 32);
            repeat (4) @(negedge clk);
            check(irq == 1, "R8", "irq held", irq, 1);
            host_write(1'b1, 32'h4);
            check(irq == 0, "R8", "irq acknowledged", irq, 0);
        end

        // R2 overfill: 23 writes, only first 20 kept
        lat = 0;
        clear_rx();
        for (int i = 0; i < DEPTH + 3; i++) begin
            sent[i] = pat(99, i);
            host_write(1'b0, sent[i]);
        end
        check(word_count == DEPTH, "R2", "count capped", word_count, DEPTH);
        host_write(1'b1, 32'h1);
        wait_idle(cyc);
        @(negedge clk);
        check(rx_n == DEPTH, "R2", "capped frame length", rx_n, DEPTH);
        check(rx[DEPTH-1] == sent[DEPTH-1], "R2", "last kept word", rx[DEPTH-1], sent[DEPTH-1]);
        host_write(1'b1, 32'h4);

        // R9 writes and go while busy
        lat = 12;
        clear_rx();
        for (int i = 0; i < 3; i++) begin
            sent[i] = pat(50, i);
            host_write(1'b0, sent[i]);
        end
        host_write(1'b1, 32'h1);
        host_write(1'b0, 32'hDEAD_BEEF);
        check(word_count == 3, "R9", "data write while busy", word_count, 3);
        host_write(1'b1, 32'h1);
        wait_idle(cyc);
        repeat (20) @(negedge clk);
        check(rx_n == 3, "R9", "go while busy sends nothing extra", rx_n, 3);
        check(rx[2] == sent[2], "R9", "frame intact", rx[2], sent[2]);
        host_write(1'b1, 32'h4);

        // R11 mirror while ready low
        lat = 0;
        xcvr_ready = 1'b0;
        @(negedge clk);
        check(host_xcvr_ready == 0, "R11", "ready mirror low", host_xcvr_ready, 0);
        xcvr_ready = 1'b1;
        @(negedge clk);

        // R10 flush mid-frame
        lat = 30;
        clear_rx();
        for (int i = 0; i < 6; i++) host_write(1'b0, pat(7, i));
        host_write(1'b1, 32'h1);
        repeat (12) @(negedge clk);
        host_write(1'b1, 32'h2);
        check(busy == 0 && word_count == 0, "R10", "flush clears busy/count",
              {busy, word_count}, 0);
        cyc = rx_n;
        repeat (80) @(negedge clk);
        check(rx_n == cyc, "R10", "no strobes after flush", rx_n, cyc);
        check(irq == 0, "R10", "flush raises no irq", irq, 0);

        // R10 flush wins over go
        wait_left = 0;
        xcvr_ready = 1'b1;
        lat = 0;
        host_write(1'b0, 32'h1234_5678);
        host_write(1'b1, 32'h3);
        check(busy == 0 && word_count == 0, "R10", "flush beats go",
              {busy, word_count}, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule